// File: doc/BRIEF.md
# Receive Ring Page Pointer Manager

This block runs the consumer side of a packet receive ring that lives in a paged buffer memory. Each page holds 256 bytes. A boundary register trails the next page to read by one page. When the next read page differs from the write pointer that the receive hardware supplies, at least one packet is waiting. The block then fetches that packet's 4-byte header one byte at a time and checks the link to the next page stored in the header. It reports a verdict: deliver, drop or fatal. For a good packet it also gives the start address and the length of the payload.

The client reads the payload itself and then strobes consume. The boundary register then moves to one page before the packet's successor. A recovery strobe discards every pending packet by pulling the boundary up to the write pointer. A fatal verdict is left in place until recovery, because the ring can no longer be trusted at that point.

Top module: `rxr_ring_mgr`

## Requirements
- R1: After reset the boundary register reads 0x5F, no header read is requested, and deliver, drop and fatal are all low.
- R2: The next read page is boundary+1, or RING_FIRST (0x46) when boundary+1 reaches RING_STOP (0x60). While the next read page equals `curr_page_i`, no header read starts, and `hdr_vld_i` has no effect.
- R3: A header fetch holds `rd_req_o` high and puts the address {read page, byte offset} on `rd_addr_o`, with the offset running 0,1,2,3. Each beat with `hdr_vld_i` advances the offset. The bytes are taken in this order: status, next-page link, size low byte, size high byte.
- R4: The computed next page is the read page plus the size in 256-byte pages, rounded up. When the result reaches RING_STOP it wraps by subtracting RING_STOP and adding RING_FIRST. A link equal to this value is accepted.
- R5: A link equal to the computed page plus one, wrapped in the same way, is also accepted.
- R6: Any other link raises `fatal_o`. Fatal stays high, and consume leaves the boundary register unchanged, until recovery.
- R7: An accepted packet is dropped (`drop_o`) when its size is below 64, above 1518, or its status ANDed with 0x0E is nonzero. Otherwise it is delivered (`deliver_o`).
- R8: For a report, `pay_addr_o` is {read page, 0x04} and `pay_len_o` is size minus 4, taken modulo 2^16.
- R9: Consume during a deliver or drop verdict sets the boundary to link-1, or to 0x5F when the link is at or below 0x46. The block then returns to idle with no flags set.
- R10: Recovery in any state sets the boundary to `curr_page_i`-1, or to 0x5F when `curr_page_i` is at or below 0x46. The block returns to idle, and a pending fatal is cleared.
- R11: At most one verdict flag is high at a time. A verdict, with its address and length, holds steady until consume or recovery, and `hdr_vld_i` during a verdict has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| curr_page_i | input | 8 | Write page pointer from the receive side |
| rd_req_o | output | 1 | Header byte read request |
| rd_addr_o | output | 16 | Header byte address {page, offset} |
| hdr_vld_i | input | 1 | Header byte valid |
| hdr_byte_i | input | 8 | Header byte data |
| consume_i | input | 1 | Packet consumed strobe |
| recover_i | input | 1 | Overflow recovery strobe |
| deliver_o | output | 1 | Packet good, payload to be read |
| drop_o | output | 1 | Packet to be skipped |
| fatal_o | output | 1 | Broken next-page link |
| pay_addr_o | output | 16 | Payload start address |
| pay_len_o | output | 16 | Payload length in bytes |
| bnry_o | output | 8 | Boundary register |

## Verification
The bench builds the block with its default limits: a 26-page ring from 0x46 to 0x5F. With that ring, packets of up to a dozen pages reach the wrap of the computed link within a few packets, and random recoveries land the boundary on both sides of the wrap. Directed cases cover sizes exactly at and one beyond the 64 and 1518 limits, a link accepted on the page-plus-one rule, a link landing on the first ring page, and a bogus link that has to survive a consume.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_REPORT = 2'd2
  } rxr_state_e;
endpackage

// File: rtl/rxr_page_wrap.sv
module rxr_page_wrap #(
  parameter int W          = 10,
  parameter int RING_FIRST = 'h46,
  parameter int RING_STOP  = 'h60
) (
  input  logic [W-1:0] page_i,
  output logic [W-1:0] page_o
);
  assign page_o = (page_i >= W'(RING_STOP)) ? page_i - W'(RING_STOP) + W'(RING_FIRST)
                                            : page_i;
endmodule

// File: rtl/rxr_page_math.sv
module rxr_page_math #(
  parameter int PAGE_W     = 8,
  parameter int OFF_W      = 8,
  parameter int SIZE_W     = 16,
  parameter int RING_FIRST = 'h46,
  parameter int RING_STOP  = 'h60,
  parameter int LINK_TRIES = 2
) (
  input  logic [PAGE_W-1:0] rd_page_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [PAGE_W-1:0] link_i,
  output logic              link_bad_o
);
  localparam int CNT_W = SIZE_W - OFF_W + 1;
  localparam int CW    = SIZE_W + 2;

  logic [CNT_W-1:0]      pages;
  logic [CW-1:0]         base;
  logic [CW-1:0]         cand_raw [LINK_TRIES];
  logic [CW-1:0]         cand     [LINK_TRIES];
  logic [LINK_TRIES-1:0] hit;

  // round the byte size up to whole pages
  assign pages = {1'b0, size_i[SIZE_W-1:OFF_W]} + CNT_W'(|size_i[OFF_W-1:0]);
  assign base  = CW'(rd_page_i) + CW'(pages);

  for (genvar g = 0; g < LINK_TRIES; g++) begin : g_try
    if (g == 0) begin : g_first
      assign cand_raw[g] = base;
    end else begin : g_next
      assign cand_raw[g] = cand[g-1] + CW'(1);
    end
    rxr_page_wrap #(.W(CW), .RING_FIRST(RING_FIRST), .RING_STOP(RING_STOP)) u_wrap (
      .page_i(cand_raw[g]),
      .page_o(cand[g])
    );
    assign hit[g] = (cand[g] == CW'(link_i));
  end

  assign link_bad_o = ~|hit;
endmodule

// File: rtl/rxr_hdr_fetch.sv
module rxr_hdr_fetch #(
  parameter int HDR_BYTES = 4,
  parameter int OFF_W     = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   active_i,
  input  logic                   vld_i,
  input  logic [7:0]             byte_i,
  output logic [OFF_W-1:0]       idx_o,
  output logic                   done_o,
  output logic [8*HDR_BYTES-1:0] hdr_o
);
  logic [OFF_W-1:0] idx_q;
  logic             beat;

  assign beat = active_i & vld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (start_i) idx_q <= '0;
    else if (beat)    idx_q <= idx_q + OFF_W'(1);
  end

  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           b_q <= '0;
      else if (beat && idx_q == OFF_W'(g))   b_q <= byte_i;
    end
    assign hdr_o[8*g +: 8] = b_q;
  end

  assign idx_o  = idx_q;
  assign done_o = beat & (idx_q == OFF_W'(HDR_BYTES-1));
endmodule

// File: rtl/rxr_bnry_reg.sv
module rxr_bnry_reg #(
  parameter int PAGE_W     = 8,
  parameter int RING_FIRST = 'h46,
  parameter int RING_STOP  = 'h60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [PAGE_W-1:0] adv_page_i,
  input  logic              rec_i,
  input  logic [PAGE_W-1:0] rec_page_i,
  output logic [PAGE_W-1:0] bnry_o,
  output logic [PAGE_W-1:0] next_rd_o
);
  localparam int PW1 = PAGE_W + 1;

  logic [PAGE_W-1:0] bnry_q;
  logic [PAGE_W:0]   inc;

  function automatic logic [PAGE_W-1:0] step_back(input logic [PAGE_W-1:0] p);
    return (p <= PAGE_W'(RING_FIRST)) ? PAGE_W'(RING_STOP - 1) : p - PAGE_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bnry_q <= PAGE_W'(RING_STOP - 1);
    else if (rec_i) bnry_q <= step_back(rec_page_i);
    else if (adv_i) bnry_q <= step_back(adv_page_i);
  end

  assign inc       = {1'b0, bnry_q} + PW1'(1);
  assign next_rd_o = (inc >= PW1'(RING_STOP)) ? PAGE_W'(RING_FIRST) : inc[PAGE_W-1:0];
  assign bnry_o    = bnry_q;
endmodule

// File: rtl/rxr_ring_mgr.sv
module rxr_ring_mgr
  import rxr_pkg::*;
#(
  parameter int PAGE_W     = 8,
  parameter int OFF_W      = 8,
  parameter int SIZE_W     = 16,
  parameter int HDR_BYTES  = 4,
  parameter int RING_FIRST = 'h46,
  parameter int RING_STOP  = 'h60,
  parameter int MIN_SIZE   = 64,
  parameter int MAX_SIZE   = 1518,
  parameter int ERR_MASK   = 'h0E,
  localparam int ADDR_W    = PAGE_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PAGE_W-1:0] curr_page_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              hdr_vld_i,
  input  logic [7:0]        hdr_byte_i,
  input  logic              consume_i,
  input  logic              recover_i,
  output logic              deliver_o,
  output logic              drop_o,
  output logic              fatal_o,
  output logic [ADDR_W-1:0] pay_addr_o,
  output logic [SIZE_W-1:0] pay_len_o,
  output logic [PAGE_W-1:0] bnry_o
);
  localparam int HDR_W = 8 * HDR_BYTES;

  rxr_state_e        state_q;
  logic [PAGE_W-1:0] rd_page_q;
  logic [PAGE_W-1:0] next_rd;
  logic [OFF_W-1:0]  idx;
  logic              hdr_done;
  logic [HDR_W-1:0]  hdr;
  logic [7:0]        status;
  logic [PAGE_W-1:0] link;
  logic [SIZE_W-1:0] size;
  logic              link_bad;
  logic              drop_c;
  logic              pending;
  logic              start;
  logic              in_fetch;
  logic              in_rep;
  logic              adv;

  assign pending  = (next_rd != curr_page_i);
  assign start    = (state_q == ST_IDLE) & pending & ~recover_i;
  assign in_fetch = (state_q == ST_FETCH);
  assign in_rep   = (state_q == ST_REPORT);
  assign adv      = in_rep & consume_i & ~link_bad & ~recover_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rd_page_q <= PAGE_W'(RING_FIRST);
    end else if (recover_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (pending) begin
          state_q   <= ST_FETCH;
          rd_page_q <= next_rd;
        end
        ST_FETCH:  if (hdr_done) state_q <= ST_REPORT;
        ST_REPORT: if (consume_i && !link_bad) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  rxr_hdr_fetch #(.HDR_BYTES(HDR_BYTES), .OFF_W(OFF_W)) u_fetch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .active_i(in_fetch),
    .vld_i   (hdr_vld_i),
    .byte_i  (hdr_byte_i),
    .idx_o   (idx),
    .done_o  (hdr_done),
    .hdr_o   (hdr)
  );

  // byte 0 status, byte 1 link, bytes 2..3 little-endian size
  assign status = hdr[7:0];
  assign link   = hdr[8 +: PAGE_W];
  assign size   = hdr[16 +: SIZE_W];

  rxr_page_math #(
    .PAGE_W(PAGE_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W),
    .RING_FIRST(RING_FIRST), .RING_STOP(RING_STOP), .LINK_TRIES(2)
  ) u_math (
    .rd_page_i (rd_page_q),
    .size_i    (size),
    .link_i    (link),
    .link_bad_o(link_bad)
  );

  rxr_bnry_reg #(.PAGE_W(PAGE_W), .RING_FIRST(RING_FIRST), .RING_STOP(RING_STOP)) u_bnry (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .adv_page_i(link),
    .rec_i     (recover_i),
    .rec_page_i(curr_page_i),
    .bnry_o    (bnry_o),
    .next_rd_o (next_rd)
  );

  assign drop_c = (size < SIZE_W'(MIN_SIZE)) | (size > SIZE_W'(MAX_SIZE)) |
                  (|(status & 8'(ERR_MASK)));

  assign rd_req_o   = in_fetch;
  assign rd_addr_o  = {rd_page_q, idx};
  assign fatal_o    = in_rep & link_bad;
  assign deliver_o  = in_rep & ~link_bad & ~drop_c;
  assign drop_o     = in_rep & ~link_bad & drop_c;
  assign pay_addr_o = {rd_page_q, OFF_W'(HDR_BYTES)};
  assign pay_len_o  = size - SIZE_W'(HDR_BYTES);
endmodule

// File: rtl/rxr_ring_mgr_chk.sv
module rxr_ring_mgr_chk #(
  parameter int PAGE_W     = 8,
  parameter int OFF_W      = 8,
  parameter int SIZE_W     = 16,
  parameter int HDR_BYTES  = 4,
  parameter int RING_FIRST = 'h46,
  parameter int RING_STOP  = 'h60
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [PAGE_W-1:0]       curr_page_i,
  input logic                    rd_req_o,
  input logic [PAGE_W+OFF_W-1:0] rd_addr_o,
  input logic                    consume_i,
  input logic                    recover_i,
  input logic                    deliver_o,
  input logic                    drop_o,
  input logic                    fatal_o,
  input logic [PAGE_W+OFF_W-1:0] pay_addr_o,
  input logic [SIZE_W-1:0]       pay_len_o,
  input logic [PAGE_W-1:0]       bnry_o
);
  logic [PAGE_W:0]   inc;
  logic [PAGE_W-1:0] nxt;
  logic              busy;

  assign inc  = {1'b0, bnry_o} + (PAGE_W+1)'(1);
  assign nxt  = (inc >= (PAGE_W+1)'(RING_STOP)) ? PAGE_W'(RING_FIRST) : inc[PAGE_W-1:0];
  assign busy = rd_req_o | deliver_o | drop_o | fatal_o;

  assert_flags_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({deliver_o, drop_o, fatal_o}));

  assert_fetch_offset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_addr_o[OFF_W-1:0] < OFF_W'(HDR_BYTES)));

  assert_empty_stays_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && nxt == curr_page_i) |=> !rd_req_o);

  assert_fatal_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fatal_o && !recover_i) |=> (fatal_o && $stable(bnry_o)));

  assert_payload_offset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deliver_o |-> (pay_addr_o[OFF_W-1:0] == OFF_W'(HDR_BYTES)));

  assert_consume_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((deliver_o || drop_o) && consume_i) |=> !busy);

  assert_recover_bnry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_i |=> (bnry_o == (($past(curr_page_i) <= PAGE_W'(RING_FIRST)) ?
                              PAGE_W'(RING_STOP - 1) : $past(curr_page_i) - PAGE_W'(1))));

  assert_verdict_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((deliver_o || drop_o) && !consume_i && !recover_i) |=>
      ($stable(pay_len_o) && $stable(pay_addr_o) && $stable({deliver_o, drop_o})));
endmodule

bind rxr_ring_mgr rxr_ring_mgr_chk #(
  .PAGE_W(PAGE_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W), .HDR_BYTES(HDR_BYTES),
  .RING_FIRST(RING_FIRST), .RING_STOP(RING_STOP)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .curr_page_i(curr_page_i),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .consume_i  (consume_i),
  .recover_i  (recover_i),
  .deliver_o  (deliver_o),
  .drop_o     (drop_o),
  .fatal_o    (fatal_o),
  .pay_addr_o (pay_addr_o),
  .pay_len_o  (pay_len_o),
  .bnry_o     (bnry_o)
);

// File: tb/rxr_ring_mgr_bench.sv
module rxr_ring_mgr_bench;
  localparam int FIRST = 'h46;
  localparam int STOP  = 'h60;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  curr_page = 8'h46;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        hdr_vld = 1'b0;
  logic [7:0]  hdr_byte = 8'h00;
  logic        consume = 1'b0;
  logic        recover = 1'b0;
  logic        deliver, drop, fatal;
  logic [15:0] pay_addr, pay_len;
  logic [7:0]  bnry;

  int n_chk = 0;
  int n_fail = 0;
  int m_bnry = 'h5F;
  int hb [4];
  bit done = 1'b0;

  always #5 clk = ~clk;

  rxr_ring_mgr u_rxr_ring_mgr (
    .clk_i(clk), .rst_ni(rst_ni), .curr_page_i(curr_page),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .hdr_vld_i(hdr_vld), .hdr_byte_i(hdr_byte),
    .consume_i(consume), .recover_i(recover), .deliver_o(deliver), .drop_o(drop),
    .fatal_o(fatal), .pay_addr_o(pay_addr), .pay_len_o(pay_len), .bnry_o(bnry)
  );

  function automatic int f_up(int v);
    return (v >= STOP) ? v - STOP + FIRST : v;
  endfunction
  function automatic int f_back(int p);
    return (p <= FIRST) ? STOP - 1 : p - 1;
  endfunction
  function automatic int f_nrd(int b);
    return f_up(b + 1);
  endfunction
  function automatic int f_calc(int rd, int size);
    return f_up(rd + size / 256 + ((size % 256) != 0 ? 1 : 0));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_recover(int curr);
    curr_page = 8'(curr);
    recover = 1'b1;
    @(negedge clk);
    recover = 1'b0;
    m_bnry = f_back(curr);
    chk("R10 bnry", int'(bnry), m_bnry);
    chk("R10 idle", int'({rd_req, deliver, drop, fatal}), 0);
  endtask

  task automatic check_empty();
    curr_page = 8'(f_nrd(m_bnry));
    hdr_vld = 1'b1;
    hdr_byte = 8'hA5;
    repeat (3) @(negedge clk);
    chk("R2 no fetch", int'({rd_req, deliver, drop, fatal}), 0);
    hdr_vld = 1'b0;
  endtask

  // one packet at the next read page; poke drives stray header beats during the verdict
  task automatic run_pkt(int status, int link, int size, int curr, bit poke);
    int rd = f_nrd(m_bnry);
    int c0 = f_calc(rd, size);
    int c1 = f_up(c0 + 1);
    bit bad = (link != c0) && (link != c1);
    bit dr = (size < 64) || (size > 1518) || ((status & 'h0E) != 0);
    int nb = 0;
    bit seen = 1'b0;
    hb[0] = status; hb[1] = link; hb[2] = size & 'hFF; hb[3] = (size >> 8) & 'hFF;
    curr_page = 8'(curr);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (deliver || drop || fatal) begin
        hdr_vld = 1'b0;
        seen = 1'b1;
        break;
      end
      if (rd_req) begin
        chk("R3 addr", int'(rd_addr), rd * 256 + nb);
        hdr_vld = 1'b1;
        hdr_byte = 8'(hb[rd_addr[1:0]]);
        nb++;
      end else begin
        hdr_vld = 1'b0;
      end
    end
    chk("R3 header beats", nb, 4);
    chk("R3 verdict seen", int'(seen), 1);
    chk(bad ? "R6 fatal" : (link == c0 ? "R4 link" : "R5 link+1"), int'(fatal), int'(bad));
    if (!bad) begin
      chk("R7 drop", int'(drop), int'(dr));
      chk("R7 deliver", int'(deliver), int'(!dr));
      chk("R8 pay_addr", int'(pay_addr), rd * 256 + 4);
      chk("R8 pay_len", int'(pay_len), (size - 4) & 'hFFFF);
      if (poke) begin
        hdr_vld = 1'b1;
        hdr_byte = 8'hFF;
        repeat (2) @(negedge clk);
        hdr_vld = 1'b0;
        chk("R11 len held", int'(pay_len), (size - 4) & 'hFFFF);
        chk("R11 flags held", int'({deliver, drop, fatal}), dr ? 2 : 4);
      end
      consume = 1'b1;
      @(negedge clk);
      consume = 1'b0;
      m_bnry = f_back(link);
      chk("R9 bnry", int'(bnry), m_bnry);
      chk("R9 idle", int'({rd_req, deliver, drop, fatal}), 0);
    end else begin
      consume = 1'b1;
      @(negedge clk);
      consume = 1'b0;
      chk("R6 fatal held", int'(fatal), 1);
      chk("R6 bnry held", int'(bnry), m_bnry);
      do_recover(curr);
    end
  endtask

  function automatic int pick_curr();
    int rd = f_nrd(m_bnry);
    int c;
    do c = FIRST + int'($urandom % (STOP - FIRST)); while (c == rd);
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    int rd, c0, sz, st, ln, r;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1 reset bnry", int'(bnry), 'h5F);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 bnry", int'(bnry), 'h5F);
    chk("R1 outputs", int'({rd_req, deliver, drop, fatal}), 0);

    check_empty();

    // directed: plain delivery with stray beats, then the size limits
    rd = f_nrd(m_bnry); run_pkt('h01, f_calc(rd, 100), 100, 'h50, 1'b1);
    rd = f_nrd(m_bnry); run_pkt(0, f_calc(rd, 64), 64, 'h50, 1'b0);
    rd = f_nrd(m_bnry); run_pkt(0, f_calc(rd, 63), 63, 'h50, 1'b0);
    rd = f_nrd(m_bnry); run_pkt(0, f_calc(rd, 1518), 1518, 'h50, 1'b1);
    rd = f_nrd(m_bnry); run_pkt(0, f_calc(rd, 1519), 1519, 'h50, 1'b0);
    rd = f_nrd(m_bnry); run_pkt('h02, f_calc(rd, 200), 200, 'h50, 1'b1);
    rd = f_nrd(m_bnry); run_pkt('h08, f_calc(rd, 300), 300, 'h50, 1'b0);
    // link on the page-plus-one rule
    rd = f_nrd(m_bnry); run_pkt(0, f_up(f_calc(rd, 500) + 1), 500, 'h50, 1'b0);
    // recovery wrapping the boundary, then a computed link that wraps
    do_recover('h46);
    chk("R10 wrap", int'(bnry), 'h5F);
    do_recover('h5F);
    run_pkt(0, 'h48, 600, 'h50, 1'b0);
    do_recover('h5F);
    run_pkt(0, 'h46, 1, 'h50, 1'b0);
    chk("R9 wrap", int'(bnry), 'h5F);
    // bogus link
    rd = f_nrd(m_bnry); c0 = f_calc(rd, 100);
    run_pkt(0, f_up(c0 + 2), 100, 'h52, 1'b0);

    for (int i = 0; i < 160; i++) begin
      rd = f_nrd(m_bnry);
      r = int'($urandom % 10);
      if (r == 0)      sz = int'($urandom % 64);
      else if (r == 1) sz = 1519 + int'($urandom % 1500);
      else if (r == 2) sz = ($urandom % 2) ? 64 : 1518;
      else             sz = 64 + int'($urandom % 1455);
      st = int'($urandom % 256);
      if ($urandom % 4 != 0) st = st & 'hF1;
      c0 = f_calc(rd, sz);
      r = int'($urandom % 8);
      if (r == 0) begin
        do ln = int'($urandom % 256); while (ln == c0 || ln == f_up(c0 + 1));
      end else if (r == 1) ln = f_up(c0 + 1);
      else ln = c0;
      run_pkt(st, ln, sz, pick_curr(), (i % 7) == 0);
      if (i % 20 == 19) do_recover(FIRST + int'($urandom % (STOP - FIRST)));
      if (i % 25 == 24) check_empty();
    end

    done = 1'b1;
    summary();
  end
endmodule